// File: doc/BRIEF.md
# Splittable Bidirectional Barrel Shifter

This block moves a 64-bit word left or right by a variable distance. It is meant for aligning mantissas before an add and for normalizing them afterwards. A static `split` input picks between two shapes. In one, the word is a single 64-bit operand. In the other, it is two 32-bit operands that are shifted independently of each other, each with its own distance and operation.

Each lane offers six things:
- shift left, in logical or arithmetic form (the two behave identically);
- rotate left;
- logical shift right;
- arithmetic shift right;
- rotate right;
- pass-through.

On a logical right shift, a lane also reports a sticky flag. The flag is the OR of every bit that dropped off the low end, which is what a rounding stage needs.

An input register stage and an output register stage sit around the shifting logic. Parameters make each stage present or absent. Both stages share one clock, one asynchronous active-low reset and one enable. The data path has no valid/ready handshake and applies no back-pressure. While `en` is high, a word enters every cycle. While `en` is low, every register holds its contents.

Top module: `shf_top`

## Requirements
- R1: Operation codes 0 and 1 shift left by the distance, filling vacated low bits with zeros and discarding bits that pass the top of the operand.
- R2: Code 2 rotates left and code 5 rotates right within the operand width, so no bit is lost and the count of ones is unchanged.
- R3: Code 3 is a logical right shift that fills the top with zeros; its sticky flag is 1 exactly when at least one bit shifted out below bit 0 was 1.
- R4: Code 4 is an arithmetic right shift that fills with the operand's top bit: bit 63 for the whole word, or bit 31 and bit 63 for the low and high lanes in split mode.
- R5: With `split` = 1, the low lane shifts `data_i[31:0]` under `ctrl_i[7:0]` and the high lane shifts `data_i[63:32]` under `ctrl_i[15:8]`. Each lane field holds a 5-bit distance in bits [4:0] and a 3-bit code in bits [7:5]. Neither lane's result or sticky depends on the other lane.
- R6: With `split` = 0, the distance is {`ctrl_i[8]`, `ctrl_i[4:0]`} (0..63) and the code is `ctrl_i[7:5]`. `ctrl_i[15:9]` is ignored, and `sticky_o[1]` is 0.
- R7: A distance of zero returns the operand unchanged in every code, with sticky 0.
- R8: A lane's sticky flag is 0 in every code other than 3.
- R9: Codes 6 and 7 pass the operand through unchanged, with sticky 0.
- R10: While `rst_n` is low, `data_o` and `sticky_o` are 0.
- R11: With both register stages present and `en` high, the result for the inputs present at one rising edge appears on the outputs after the following rising edge, two cycles after the inputs are applied.
- R12: While `en` is low, both stages hold, and `data_o` and `sticky_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both register stages |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Common enable of the register stages |
| split | input | 1 | 1: two 32-bit lanes; 0: one 64-bit operand (static) |
| data_i | input | 64 | Operand word |
| ctrl_i | input | 16 | Two 8-bit lane fields: distance [4:0], code [7:5] |
| data_o | output | 64 | Shifted or rotated result |
| sticky_o | output | 2 | Per-lane sticky flag; bit 0 is the only one used in 64-bit mode |

## Verification
The bench drives the lane seam in split mode with the two lanes holding different signs and different codes.
- A design that let bits cross between lanes would show wrong upper bits in the low lane.
- A design that took the fill bit from bit 63 would get the low lane's arithmetic fill wrong.

It tests distances of 0, 1, 31, 32 and 63, plus the wide distance that needs `ctrl_i[8]`. A dropped sixth distance bit turns a 32-place shift into no shift. An off-by-one mask makes sticky miss, or wrongly include, the bit at the distance boundary. Rotates at the extreme distances catch a wrap that leaks zeros. An enable-low window catches a stage that keeps loading, and a two-step latency probe catches a missing or extra stage.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_ASL = 3'd1,
    SH_ROL = 3'd2,
    SH_LSR = 3'd3,
    SH_ASR = 3'd4,
    SH_ROR = 3'd5,
    SH_PS6 = 3'd6,
    SH_PS7 = 3'd7
  } shf_mode_e;

  localparam int unsigned MODE_W = 3;
endpackage

// File: rtl/shf_lane.sv
module shf_lane
  import shf_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  d,
  input  logic [AW-1:0] amt,
  input  shf_mode_e     mode,
  output logic [W-1:0]  q,
  output logic          sticky
);
  logic [2*W-1:0] dbl;
  logic [2*W-1:0] rol_full;
  logic [2*W-1:0] ror_full;
  logic [W-1:0]   lsl;
  logic [W-1:0]   lsr;
  logic [W-1:0]   asr;
  logic [W-1:0]   lost_mask;

  assign dbl       = {d, d};
  assign rol_full  = dbl << amt;
  assign ror_full  = dbl >> amt;
  assign lsl       = d << amt;
  assign lsr       = d >> amt;
  assign asr       = $signed(d) >>> amt;
  assign lost_mask = ~({W{1'b1}} << amt);

  always_comb begin
    unique case (mode)
      SH_LSL, SH_ASL: q = lsl;
      SH_ROL:         q = rol_full[2*W-1:W];
      SH_LSR:         q = lsr;
      SH_ASR:         q = asr;
      SH_ROR:         q = ror_full[W-1:0];
      default:        q = d;
    endcase
  end

  // only a logical right shift reports lost bits
  assign sticky = (mode == SH_LSR) && (|(d & lost_mask));
endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
  parameter int unsigned W      = 8,
  parameter bit          EN_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
      end
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/shf_top.sv
module shf_top
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter bit          IN_REG  = 1'b1,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned LANES   = 2,
  localparam int unsigned LANE_W  = DATA_W / LANES,
  localparam int unsigned WAMT_W  = $clog2(DATA_W),
  localparam int unsigned LAMT_W  = $clog2(LANE_W),
  localparam int unsigned LCTRL_W = LAMT_W + MODE_W,
  localparam int unsigned CTRL_W  = LANES * LCTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              split,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  sticky_o
);
  logic [DATA_W-1:0] stg_data;
  logic [CTRL_W-1:0] stg_ctrl;
  logic [DATA_W-1:0] res_data;
  logic [LANES-1:0]  res_sticky;

  shf_stage #(.W(DATA_W + CTRL_W), .EN_REG(IN_REG)) u_in_stage (
    .clk(clk), .rst_n(rst_n), .en(en),
    .d({ctrl_i, data_i}),
    .q({stg_ctrl, stg_data})
  );

  // whole-word shifter: distance msb comes from the first bit of lane 1's field
  logic [DATA_W-1:0] wide_q;
  logic              wide_st;
  logic [WAMT_W-1:0] wide_amt;
  assign wide_amt = {stg_ctrl[LCTRL_W], stg_ctrl[LAMT_W-1:0]};

  shf_lane #(.W(DATA_W)) u_wide (
    .d(stg_data),
    .amt(wide_amt),
    .mode(shf_mode_e'(stg_ctrl[LAMT_W +: MODE_W])),
    .q(wide_q),
    .sticky(wide_st)
  );

  logic [DATA_W-1:0] split_q;
  logic [LANES-1:0]  split_st;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      shf_lane #(.W(LANE_W)) u_lane (
        .d(stg_data[g*LANE_W +: LANE_W]),
        .amt(stg_ctrl[g*LCTRL_W +: LAMT_W]),
        .mode(shf_mode_e'(stg_ctrl[g*LCTRL_W + LAMT_W +: MODE_W])),
        .q(split_q[g*LANE_W +: LANE_W]),
        .sticky(split_st[g])
      );
    end
  endgenerate

  always_comb begin
    if (split) begin
      res_data   = split_q;
      res_sticky = split_st;
    end else begin
      res_data   = wide_q;
      res_sticky = {{(LANES-1){1'b0}}, wide_st};
    end
  end

  shf_stage #(.W(DATA_W + LANES), .EN_REG(OUT_REG)) u_out_stage (
    .clk(clk), .rst_n(rst_n), .en(en),
    .d({res_sticky, res_data}),
    .q({sticky_o, data_o})
  );
endmodule

// File: rtl/shf_top_chk.sv
module shf_top_chk #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned CTRL_W  = 16,
  parameter int unsigned LCTRL_W = 8,
  parameter int unsigned LAMT_W  = 5,
  parameter bit          OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              split,
  input logic [DATA_W-1:0] stg_data,
  input logic [CTRL_W-1:0] stg_ctrl,
  input logic [DATA_W-1:0] res_data,
  input logic [1:0]        res_sticky,
  input logic [DATA_W-1:0] data_o,
  input logic [1:0]        sticky_o
);
  logic [2:0] wmode;
  logic       wzero;
  assign wmode = stg_ctrl[LAMT_W +: 3];
  assign wzero = (stg_ctrl[LAMT_W-1:0] == '0) && !stg_ctrl[LCTRL_W];

  // R7
  zero_dist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && wzero) |-> (res_data == stg_data && res_sticky == 2'b00));

  // R2
  rot_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && (wmode == 3'd2 || wmode == 3'd5)) |->
      ($countones(res_data) == $countones(stg_data)));

  // R8
  sticky_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && wmode != 3'd3) |-> (res_sticky == 2'b00));

  // R6
  wide_hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !split |-> !res_sticky[1]);

  generate
    if (OUT_REG) begin : g_out
      // R11
      out_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (data_o == $past(res_data) && sticky_o == $past(res_sticky)));

      // R12
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(data_o) && $stable(sticky_o)));

      // R10
      reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (data_o == '0 && sticky_o == '0));
    end
  endgenerate
endmodule

bind shf_top shf_top_chk #(
  .DATA_W(DATA_W), .CTRL_W(CTRL_W), .LCTRL_W(LCTRL_W),
  .LAMT_W(LAMT_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .split(split),
  .stg_data(stg_data), .stg_ctrl(stg_ctrl),
  .res_data(res_data), .res_sticky(res_sticky),
  .data_o(data_o), .sticky_o(sticky_o)
);

// File: tb/shf_top_test.sv
module shf_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        split = 1'b0;
  logic [63:0] data_i = '0;
  logic [15:0] ctrl_i = '0;
  logic [63:0] data_o;
  logic [1:0]  sticky_o;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  shf_top uut (
    .clk(clk), .rst_n(rst_n), .en(en), .split(split),
    .data_i(data_i), .ctrl_i(ctrl_i),
    .data_o(data_o), .sticky_o(sticky_o)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void ref_lane(input logic [63:0] d, input int w,
                                   input int amt, input int mode,
                                   output logic [63:0] q, output logic st);
    q  = '0;
    st = 1'b0;
    for (int i = 0; i < w; i++) begin
      case (mode)
        0, 1: q[i] = (i >= amt) ? d[i-amt] : 1'b0;
        2:    q[i] = d[(i - amt + w) % w];
        3:    q[i] = (i + amt < w) ? d[i+amt] : 1'b0;
        4:    q[i] = (i + amt < w) ? d[i+amt] : d[w-1];
        5:    q[i] = d[(i + amt) % w];
        default: q[i] = d[i];
      endcase
    end
    if (mode == 3)
      for (int j = 0; j < amt; j++) st = st | d[j];
  endfunction

  function automatic void model(input bit sp, input logic [63:0] d,
                                input logic [15:0] c,
                                output logic [63:0] ed, output logic [1:0] es);
    logic [63:0] q0, q1;
    logic s0, s1;
    if (sp) begin
      ref_lane({32'b0, d[31:0]}, 32, int'(c[4:0]), int'(c[7:5]), q0, s0);
      ref_lane({32'b0, d[63:32]}, 32, int'(c[12:8]), int'(c[15:13]), q1, s1);
      ed = {q1[31:0], q0[31:0]};
      es = {s1, s0};
    end else begin
      ref_lane(d, 64, int'({c[8], c[4:0]}), int'(c[7:5]), q0, s0);
      ed = q0;
      es = {1'b0, s0};
    end
  endfunction

  logic [63:0] last_d;
  logic [1:0]  last_s;

  task automatic run(input bit sp, input logic [63:0] d, input logic [15:0] c,
                     input string req);
    logic [63:0] ed;
    logic [1:0]  es;
    @(negedge clk);
    split = sp; data_i = d; ctrl_i = c; en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    model(sp, d, c, ed, es);
    check(data_o == ed, req, data_o, ed);
    check(sticky_o == es, req, {62'b0, sticky_o}, {62'b0, es});
    last_d = ed;
    last_s = es;
  endtask

  function automatic logic [15:0] wctl(input int amt, input int mode, input logic [6:0] junk);
    logic [15:0] c;
    c = {junk, 9'b0};
    c[4:0] = amt[4:0];
    c[7:5] = mode[2:0];
    c[8]   = amt[5];
    return c;
  endfunction

  function automatic logic [15:0] sctl(input int a0, input int m0, input int a1, input int m1);
    return {m1[2:0], a1[4:0], m0[2:0], a0[4:0]};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] a;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(data_o == 64'd0, "R10", data_o, 64'd0);
    check(sticky_o == 2'b00, "R10", {62'b0, sticky_o}, 64'd0);
    rst_n = 1'b1;

    a = 64'hF0E1_D2C3_B4A5_9687;
    // R1 left shifts, both codes
    run(0, a, wctl(4, 0, 7'h00), "R1");
    run(0, a, wctl(63, 1, 7'h00), "R1");
    // R2 rotates at extremes
    run(0, a, wctl(63, 2, 7'h00), "R2");
    run(0, a, wctl(1, 5, 7'h00), "R2");
    // R3 sticky on and off at the boundary
    run(0, 64'h0000_0000_0000_0080, wctl(8, 3, 7'h00), "R3");
    run(0, 64'h0000_0000_0000_0100, wctl(8, 3, 7'h00), "R3");
    // R4 arithmetic fill, whole word
    run(0, 64'h8000_0000_0000_0000, wctl(63, 4, 7'h00), "R4");
    // R4 and R5 low lane negative, high lane positive
    run(1, 64'h7000_0000_8000_0000, sctl(31, 4, 31, 4), "R4");
    run(1, 64'hFFFF_FFFF_0000_0001, sctl(1, 3, 4, 2), "R5");
    // R6 distance 32 needs bit 8; junk in upper field ignored
    run(0, a, wctl(32, 3, 7'h7F), "R6");
    run(0, a, wctl(33, 0, 7'h55), "R6");
    // R7 zero distance for each code
    for (int m = 0; m < 6; m++) run(0, a, wctl(0, m, 7'h00), "R7");
    run(1, a, sctl(0, 3, 0, 4), "R7");
    // R8 non-logical-right codes never raise sticky
    run(0, 64'hFFFF_FFFF_FFFF_FFFF, wctl(20, 4, 7'h00), "R8");
    run(1, 64'hFFFF_FFFF_FFFF_FFFF, sctl(5, 5, 9, 4), "R8");
    // R9 codes 6 and 7 pass through
    run(0, a, wctl(17, 6, 7'h00), "R9");
    run(1, a, sctl(3, 7, 11, 6), "R9");

    // R11 latency: B's result must not appear one cycle early
    run(0, a, wctl(5, 0, 7'h00), "R11");
    @(negedge clk);
    ctrl_i = wctl(9, 5, 7'h00);
    @(negedge clk);
    check(data_o == last_d, "R11", data_o, last_d);
    @(negedge clk);
    begin
      logic [63:0] ed; logic [1:0] es;
      model(0, a, wctl(9, 5, 7'h00), ed, es);
      check(data_o == ed, "R11", data_o, ed);
      last_d = ed; last_s = es;
    end

    // R12 enable low holds
    en = 1'b0;
    data_i = ~a; ctrl_i = wctl(12, 3, 7'h00);
    repeat (3) @(negedge clk);
    check(data_o == last_d, "R12", data_o, last_d);
    check(sticky_o == last_s, "R12", {62'b0, sticky_o}, {62'b0, last_s});

    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [63:0] rd;
      logic [15:0] rc;
      bit sp;
      rd = {$urandom(), $urandom()};
      rc = 16'($urandom());
      sp = 1'($urandom());
      if (sp) run(1, rd, rc, "R5");
      else begin
        case (int'(rc[7:5]))
          0, 1: run(0, rd, rc, "R1");
          2, 5: run(0, rd, rc, "R2");
          3: run(0, rd, rc, "R3");
          4: run(0, rd, rc, "R4");
          default: run(0, rd, rc, "R9");
        endcase
      end
    end

    // R10 reset after traffic
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(data_o == 64'd0, "R10", data_o, 64'd0);
    check(sticky_o == 2'b00, "R10", {62'b0, sticky_o}, 64'd0);
    finish_run();
  end
endmodule